// File: doc/BRIEF.md
# Segmented Linear Address Generator

This block turns each memory access, given as a segment choice plus an offset, into a linear address. It holds a small hidden cache of six segment registers (selector, base and limit for each), written through a load port by the descriptor loader. For every request it picks the segment the access kind implies, or an explicit override where one is allowed. It reads that segment's cached entry and then translates in one of two ways. In real mode it shifts the selector left by four bits and adds a 16-bit offset. In protected mode it checks a 32-bit offset against the cached limit and adds the cached base.

The result is registered, so it appears one cycle after the request. It carries a valid flag and a fault flag. A fault stands for a general protection fault, and a faulting access produces the address zero. If the segments are set up flat (base zero, limit all ones), protected mode passes offsets through unchanged. Reset leaves every segment in that flat state.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset out_valid, out_fault and out_addr are 0, and every segment holds selector 0, base 0 and limit 32'hFFFF_FFFF.
- R2: A request with req_valid=1 gives out_valid=1 one clock later. A cycle without a request gives out_valid=0 and out_fault=0 one clock later.
- R3: In real mode (real_mode=1), out_addr = ({selector, 4'h0} + req_off[15:0]) modulo 2^20, zero-extended to 32 bits. req_off[31:16] is ignored, and only R6 can raise a fault.
- R4: Segment numbers are 0=ES, 1=CS, 2=SS, 3=DS, 4=FS, 5=GS. The implied segment for req_kind is 2'b00 (fetch) CS, 2'b01 (data) DS, 2'b10 (stack) SS and 2'b11 (string destination) ES.
- R5: With ovr_valid=1, ovr_seg replaces the implied segment for kinds 2'b01 and 2'b10. For kinds 2'b00 and 2'b11 the override is ignored.
- R6: An override that applies and names segment 6 or 7 gives out_fault=1 and out_addr=0 in either mode.
- R7: In protected mode (real_mode=0), an offset greater than the segment limit gives out_fault=1 and out_addr=0. An offset equal to the limit passes.
- R8: In protected mode, when the limit check passes, out_addr = (base + req_off) modulo 2^32 and out_fault=0.
- R9: ld_valid=1 with ld_seg below 6 writes ld_sel, ld_base and ld_limit into that segment. A request in the same cycle still sees the old contents, and later requests see the new ones. A load with ld_seg of 6 or 7 changes nothing.
- R10: A segment with base 0 and limit 32'hFFFF_FFFF returns the offset unchanged in protected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| real_mode | input | 1 | 1 = real-mode translation, 0 = protected mode |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | Access kind (fetch, data, stack, string destination) |
| ovr_valid | input | 1 | Explicit segment override present |
| ovr_seg | input | 3 | Override segment number |
| req_off | input | 32 | Offset |
| ld_valid | input | 1 | Write a segment cache entry |
| ld_seg | input | 3 | Segment number to write |
| ld_sel | input | 16 | Selector value to store |
| ld_base | input | 32 | Base value to store |
| ld_limit | input | 32 | Limit value to store |
| out_valid | output | 1 | Translation result valid |
| out_fault | output | 1 | Protection fault on this result |
| out_addr | output | 32 | Linear address (0 on fault) |

## Verification
A cache load and a translation can fall in the same cycle and target the same segment. The write must not leak into the translation already under way. The bench provokes this by loading new base and limit values into the data segment while it issues a data request in that same cycle. It judges the first result against the old flat contents and the request that follows against the new base, and then confirms that a load to an out-of-range segment number leaves that base in effect.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_W  = 3;
  localparam int SEL_W  = 16;
  localparam int OFF_W  = 32;
  localparam int REAL_W = 20;

  typedef logic [SEG_W-1:0] seg_id_t;

  localparam seg_id_t SEG_ES = 3'd0;
  localparam seg_id_t SEG_CS = 3'd1;
  localparam seg_id_t SEG_SS = 3'd2;
  localparam seg_id_t SEG_DS = 3'd3;

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'b00,
    ACC_DATA   = 2'b01,
    ACC_STACK  = 2'b10,
    ACC_STRDST = 2'b11
  } acc_kind_t;

  function automatic seg_id_t implied_seg(input acc_kind_t k);
    case (k)
      ACC_FETCH: return SEG_CS;
      ACC_DATA:  return SEG_DS;
      ACC_STACK: return SEG_SS;
      default:   return SEG_ES;
    endcase
  endfunction

  function automatic logic [REAL_W-1:0] real_linear(input logic [SEL_W-1:0] sel,
                                                    input logic [SEL_W-1:0] off);
    return {sel, 4'h0} + {4'h0, off};
  endfunction

  function automatic logic prot_over(input logic [OFF_W-1:0] off,
                                     input logic [OFF_W-1:0] lim);
    return off > lim;
  endfunction

  function automatic logic [OFF_W-1:0] prot_linear(input logic [OFF_W-1:0] base,
                                                   input logic [OFF_W-1:0] off);
    return base + off;
  endfunction
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_pkg::*;
#(
  parameter int NUM_SEG = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  seg_id_t          ld_seg,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic [OFF_W-1:0] ld_base,
  input  logic [OFF_W-1:0] ld_limit,
  input  seg_id_t          rd_seg,
  output logic             rd_ok,
  output logic [SEL_W-1:0] rd_sel,
  output logic [OFF_W-1:0] rd_base,
  output logic [OFF_W-1:0] rd_limit
);
  localparam int IDX_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;

  logic [SEL_W-1:0] sel_q   [NUM_SEG];
  logic [OFF_W-1:0] base_q  [NUM_SEG];
  logic [OFF_W-1:0] limit_q [NUM_SEG];
  logic             ld_ok;
  logic [IDX_W-1:0] rd_idx;

  assign ld_ok  = ld_valid && (int'(ld_seg) < NUM_SEG);
  assign rd_ok  = int'(rd_seg) < NUM_SEG;
  assign rd_idx = rd_ok ? IDX_W'(rd_seg) : '0;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sel_q[g]   <= '0;
        base_q[g]  <= '0;
        limit_q[g] <= '1;
      end else if (ld_ok && (int'(ld_seg) == g)) begin
        sel_q[g]   <= ld_sel;
        base_q[g]  <= ld_base;
        limit_q[g] <= ld_limit;
      end
    end
  end

  always_comb begin
    rd_sel   = rd_ok ? sel_q[rd_idx]   : '0;
    rd_base  = rd_ok ? base_q[rd_idx]  : '0;
    rd_limit = rd_ok ? limit_q[rd_idx] : '0;
  end

  AST_LOAD_STORES_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ok |=> base_q[IDX_W'($past(ld_seg))] == $past(ld_base)); // R9
endmodule

// File: rtl/seg_pick.sv
module seg_pick
  import seg_pkg::*;
(
  input  acc_kind_t kind,
  input  logic      ovr_valid,
  input  seg_id_t   ovr_seg,
  output logic      ovr_used,
  output seg_id_t   seg
);
  assign ovr_used = ovr_valid && ((kind == ACC_DATA) || (kind == ACC_STACK));
  assign seg      = ovr_used ? ovr_seg : implied_seg(kind);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
(
  input  logic             real_mode,
  input  logic             seg_ok,
  input  logic [SEL_W-1:0] sel,
  input  logic [OFF_W-1:0] base,
  input  logic [OFF_W-1:0] limit,
  input  logic [OFF_W-1:0] off,
  output logic             limit_hit,
  output logic             fault,
  output logic [OFF_W-1:0] addr
);
  logic [REAL_W-1:0] real_addr;
  logic [OFF_W-1:0]  prot_addr;

  assign real_addr = real_linear(sel, off[SEL_W-1:0]);
  assign prot_addr = prot_linear(base, off);
  assign limit_hit = !real_mode && prot_over(off, limit);
  assign fault     = !seg_ok || limit_hit;

  always_comb begin
    if (fault)          addr = '0;
    else if (real_mode) addr = {{(OFF_W-REAL_W){1'b0}}, real_addr};
    else                addr = prot_addr;
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_pkg::*;
#(
  parameter int NUM_SEG = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        real_mode,
  input  logic        req_valid,
  input  logic [1:0]  req_kind,
  input  logic        ovr_valid,
  input  logic [2:0]  ovr_seg,
  input  logic [31:0] req_off,
  input  logic        ld_valid,
  input  logic [2:0]  ld_seg,
  input  logic [15:0] ld_sel,
  input  logic [31:0] ld_base,
  input  logic [31:0] ld_limit,
  output logic        out_valid,
  output logic        out_fault,
  output logic [31:0] out_addr
);
  seg_id_t          pick_seg;
  logic             ovr_used;
  logic             seg_ok;
  logic [SEL_W-1:0] c_sel;
  logic [OFF_W-1:0] c_base, c_limit;
  logic             x_fault, x_limit_hit;
  logic [OFF_W-1:0] x_addr;

  seg_pick u_pick (
    .kind      (acc_kind_t'(req_kind)),
    .ovr_valid (ovr_valid),
    .ovr_seg   (ovr_seg),
    .ovr_used  (ovr_used),
    .seg       (pick_seg)
  );

  seg_regfile #(.NUM_SEG(NUM_SEG)) u_cache (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_valid (ld_valid),
    .ld_seg   (ld_seg),
    .ld_sel   (ld_sel),
    .ld_base  (ld_base),
    .ld_limit (ld_limit),
    .rd_seg   (pick_seg),
    .rd_ok    (seg_ok),
    .rd_sel   (c_sel),
    .rd_base  (c_base),
    .rd_limit (c_limit)
  );

  seg_xlate u_xlate (
    .real_mode (real_mode),
    .seg_ok    (seg_ok),
    .sel       (c_sel),
    .base      (c_base),
    .limit     (c_limit),
    .off       (req_off),
    .limit_hit (x_limit_hit),
    .fault     (x_fault),
    .addr      (x_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= req_valid;
      out_fault <= req_valid && x_fault;
      out_addr  <= req_valid ? x_addr : '0;
    end
  end

  AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid && !out_fault); // R2
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> out_valid && (out_addr == '0)); // R7
  AST_REAL_20BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && real_mode && (!ovr_used || seg_ok)) |=> !out_fault && (out_addr[31:20] == '0)); // R3
  AST_LIMIT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && x_limit_hit) |=> out_fault); // R7
endmodule

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        real_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic        ovr_valid = 1'b0;
  logic [2:0]  ovr_seg = 3'd0;
  logic [31:0] req_off = '0;
  logic        ld_valid = 1'b0;
  logic [2:0]  ld_seg = 3'd0;
  logic [15:0] ld_sel = '0;
  logic [31:0] ld_base = '0;
  logic [31:0] ld_limit = '0;
  logic        out_valid, out_fault;
  logic [31:0] out_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg_addr_gen i_seg_addr_gen (
    .clk(clk), .rst_n(rst_n), .real_mode(real_mode), .req_valid(req_valid),
    .req_kind(req_kind), .ovr_valid(ovr_valid), .ovr_seg(ovr_seg), .req_off(req_off),
    .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel), .ld_base(ld_base),
    .ld_limit(ld_limit), .out_valid(out_valid), .out_fault(out_fault), .out_addr(out_addr)
  );

  typedef struct packed {
    logic        rm;
    logic [1:0]  kind;
    logic        ov;
    logic [2:0]  os;
    logic [31:0] off;
    logic        efault;
    logic [31:0] eaddr;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b00, 1'b0, 3'd0, 32'h0000_1234, 1'b0, 32'h0000_8124}, // R3 R4 fetch CS
    '{1'b1, 2'b10, 1'b0, 3'd0, 32'h0000_0004, 1'b0, 32'h0000_8124}, // R3 R4 stack SS
    '{1'b1, 2'b01, 1'b0, 3'd0, 32'h0000_8124, 1'b0, 32'h0000_8124}, // R3 R4 data DS
    '{1'b1, 2'b01, 1'b1, 3'd4, 32'h0000_0010, 1'b0, 32'h0000_0000}, // R3 R5 20-bit wrap
    '{1'b1, 2'b01, 1'b0, 3'd0, 32'hABCD_0005, 1'b0, 32'h0000_0005}, // R3 upper ignored
    '{1'b1, 2'b11, 1'b1, 3'd4, 32'h0000_0100, 1'b0, 32'h0000_0100}, // R5 ignored on strdst
    '{1'b1, 2'b01, 1'b1, 3'd6, 32'h0000_0100, 1'b1, 32'h0000_0000}, // R6 real
    '{1'b0, 2'b00, 1'b0, 3'd0, 32'h000F_FFFF, 1'b0, 32'h004F_FFFF}, // R7 at limit
    '{1'b0, 2'b00, 1'b0, 3'd0, 32'h0010_0000, 1'b1, 32'h0000_0000}, // R7 over limit
    '{1'b0, 2'b01, 1'b0, 3'd0, 32'h0000_2000, 1'b0, 32'h0000_1000}, // R8 wrap
    '{1'b0, 2'b10, 1'b0, 3'd0, 32'h0000_0010, 1'b0, 32'h8000_0010}, // R8 stack
    '{1'b0, 2'b10, 1'b1, 3'd5, 32'h0000_0000, 1'b0, 32'h0000_0000}, // R5 R7 zero limit
    '{1'b0, 2'b10, 1'b1, 3'd5, 32'h0000_0001, 1'b1, 32'h0000_0000}, // R7 over zero limit
    '{1'b0, 2'b00, 1'b1, 3'd4, 32'h0000_0100, 1'b0, 32'h0040_0100}, // R5 ignored on fetch
    '{1'b0, 2'b11, 1'b0, 3'd0, 32'h0000_1000, 1'b1, 32'h0000_0000}, // R4 R7 ES over
    '{1'b0, 2'b11, 1'b0, 3'd0, 32'h0000_0FFF, 1'b0, 32'h0010_0FFF}, // R4 R8 ES
    '{1'b0, 2'b01, 1'b1, 3'd7, 32'h0000_0000, 1'b1, 32'h0000_0000}  // R6 protected
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] s, input logic [15:0] sel,
                      input logic [31:0] b, input logic [31:0] l);
    ld_valid = 1'b1; ld_seg = s; ld_sel = sel; ld_base = b; ld_limit = l;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic request(input logic rm, input logic [1:0] k, input logic ov,
                         input logic [2:0] os, input logic [31:0] off);
    real_mode = rm; req_kind = k; ovr_valid = ov; ovr_seg = os; req_off = off;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; ld_valid = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic ef, input logic [31:0] ea);
    check(out_valid === 1'b1, req, {31'b0, out_valid}, 32'h1);
    check(out_fault === ef, req, {31'b0, out_fault}, {31'b0, ef});
    check(out_addr === ea, req, out_addr, ea);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(out_valid === 1'b0 && out_fault === 1'b0, "R1", {30'b0, out_valid, out_fault}, 32'h0);
    check(out_addr === 32'h0, "R1", out_addr, 32'h0);

    request(1'b0, 2'b01, 1'b0, 3'd0, 32'hDEAD_BEEF);
    expect_out("R1 R10 flat", 1'b0, 32'hDEAD_BEEF);
    request(1'b0, 2'b00, 1'b0, 3'd0, 32'hFFFF_FFFF);
    expect_out("R10 top offset", 1'b0, 32'hFFFF_FFFF);
    request(1'b1, 2'b10, 1'b0, 3'd0, 32'h0000_1234);
    expect_out("R1 R3 sel zero", 1'b0, 32'h0000_1234);
    @(negedge clk);
    check(out_valid === 1'b0, "R2 idle", {31'b0, out_valid}, 32'h0);

    // R9 load in same cycle as request to DS: old flat view first
    ld_valid = 1'b1; ld_seg = 3'd3; ld_sel = 16'h0; ld_base = 32'h0000_0100; ld_limit = 32'h0000_00FF;
    request(1'b0, 2'b01, 1'b0, 3'd0, 32'h0000_0010);
    expect_out("R9 same-cycle old", 1'b0, 32'h0000_0010);
    request(1'b0, 2'b01, 1'b0, 3'd0, 32'h0000_0010);
    expect_out("R9 new base", 1'b0, 32'h0000_0110);
    load(3'd6, 16'h0, 32'h0000_5000, 32'hFFFF_FFFF);
    request(1'b0, 2'b01, 1'b0, 3'd0, 32'h0000_0010);
    expect_out("R9 bad load ignored", 1'b0, 32'h0000_0110);

    load(3'd0, 16'h0000, 32'h0010_0000, 32'h0000_0FFF);
    load(3'd1, 16'h06EF, 32'h0040_0000, 32'h000F_FFFF);
    load(3'd2, 16'h0812, 32'h8000_0000, 32'h0000_FFFF);
    load(3'd3, 16'h0000, 32'hFFFF_F000, 32'hFFFF_FFFF);
    load(3'd4, 16'hFFFF, 32'h0000_1000, 32'h0000_0010);
    load(3'd5, 16'h1234, 32'h0000_0000, 32'h0000_0000);

    for (int i = 0; i < NV; i++) begin
      request(VECS[i].rm, VECS[i].kind, VECS[i].ov, VECS[i].os, VECS[i].off);
      expect_out($sformatf("R3-R8 vector %0d", i), VECS[i].efault, VECS[i].eaddr);
    end

    @(negedge clk);
    check(out_valid === 1'b0 && out_fault === 1'b0, "R2 idle after fault", {30'b0, out_valid, out_fault}, 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule